// File: doc/BRIEF.md
# Phase-Frequency Detector with Direction Control

This block compares a divided-RF pulse stream with a divided-reference pulse stream. It drives the UP and DOWN requests that steer an external charge pump. All inputs are synchronous to `clk`, and a pulse counts at its rising edge. A direction input sets which stream drives UP and which drives DOWN, and the same input swaps the two monitor outputs. A detector enable forces both pump requests low. A monitor enable gates the two registered copies of the input streams.

The comparator is a four-state machine. The states are `PD_IDLE`, `PD_UP_ON` (the UP-side edge came first), `PD_DN_ON` (the DOWN-side edge came first) and `PD_OVERLAP`, in which both requests are high for one cycle and the period closes.

The transitions out of `PD_IDLE` and `PD_OVERLAP` go to `PD_OVERLAP` on both edges together, to `PD_UP_ON` on the UP-side edge alone and to `PD_DN_ON` on the DOWN-side edge alone. Otherwise they go to `PD_IDLE`. `PD_UP_ON` goes to `PD_OVERLAP` on the DOWN-side edge and `PD_DN_ON` goes to `PD_OVERLAP` on the UP-side edge. Disabling the detector forces `PD_IDLE`.

A lock filter has two states, `LK_HUNT` and `LK_HELD`. It moves `LK_HUNT` to `LK_HELD` after `LOCK_PERIODS` consecutive quiet periods. It drops `LK_HELD` to `LK_HUNT` as soon as the one-sided error in a period exceeds `ERR_THRESH` cycles. A 2-bit gain code is decoded into a scaled pump-current factor.

Top module: `pfd_dir_ctrl`

## Requirements
- R1: With `dir_sel`=1 the reference stream drives UP and the RF stream drives DOWN. If one edge precedes the other by k cycles (k≥1), the leading request is high for k+1 cycles and the other is high for 1 cycle, and the two are high together in the last cycle.
- R2: With `dir_sel`=0 the roles are reversed: the RF stream drives UP and the reference stream drives DOWN, with the same pulse widths as R1.
- R3: Edges arriving in the same cycle raise both `pump_up` and `pump_dn` for exactly one cycle, so that no phase error is too small to produce a pulse. A rising edge on an input causes the request to appear after the next clock edge.
- R4: While `det_en`=0, `pump_up` and `pump_dn` are low whatever the inputs do, and `locked` is low from the clock edge after `det_en` falls.
- R5: The monitor outputs are registered with one cycle of latency. With `dir_sel`=1, `mon_a` carries the RF stream and `mon_b` carries the reference stream. With `dir_sel`=0 they are swapped.
- R6: While `mon_en`=0, `mon_a` and `mon_b` are low from the next clock edge.
- R7: `gain_scale` decodes `gain_code` as 00→2, 01→3, 10→5 and 11→8. These are the factors 1.0, 1.5, 2.5 and 4.0 multiplied by two.
- R8: A period is quiet when its one-sided error (the cycles in `PD_UP_ON` or `PD_DN_ON`) is at most `ERR_THRESH`. `locked` rises on the clock edge after the overlap cycle of the `LOCK_PERIODS`-th consecutive quiet period.
- R9: If a period's error count goes above `ERR_THRESH`, `locked` falls at once and the count of quiet periods restarts from zero.
- R10: After reset, `pump_up`, `pump_dn`, `mon_a`, `mon_b` and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_pulse | input | 1 | Divided-RF pulse stream |
| ref_pulse | input | 1 | Divided-reference pulse stream |
| dir_sel | input | 1 | Loop polarity and monitor swap |
| det_en | input | 1 | Detector enable |
| mon_en | input | 1 | Monitor output enable |
| gain_code | input | 2 | Pump gain selection |
| pump_up | output | 1 | Source-current request |
| pump_dn | output | 1 | Sink-current request |
| mon_a | output | 1 | Monitor: RF when dir_sel=1, else reference |
| mon_b | output | 1 | Monitor: reference when dir_sel=1, else RF |
| gain_scale | output | 4 | Gain factor times two |
| locked | output | 1 | Filtered lock flag |

## Verification
A comparator state that is stuck or taken wrongly shows up as a wrong pulse width on `pump_up` or `pump_dn` within the same comparison period. This shows at the latest at the overlap cycle, which is where the scoreboard measures both widths. A lock counter that is off by one, or that does not restart, moves the rise of `locked` by a whole period. So the bench checks `locked` after every period across the threshold boundary (error of 2 cycles accepted, 3 rejected). Swapped monitor or direction wiring shows after a single cycle.

// File: rtl/pfd_dir_pkg.sv
package pfd_dir_pkg;

    typedef enum logic [1:0] {
        PD_IDLE,
        PD_UP_ON,
        PD_DN_ON,
        PD_OVERLAP
    } pd_state_e;

    typedef enum logic {
        LK_HUNT,
        LK_HELD
    } lk_state_e;

    localparam int GAIN_W = 4;

    function automatic logic [GAIN_W-1:0] gain_decode(input logic [1:0] code);
        logic [GAIN_W-1:0] f;
        unique case (code)
            2'b00: f = GAIN_W'(2);
            2'b01: f = GAIN_W'(3);
            2'b10: f = GAIN_W'(5);
            2'b11: f = GAIN_W'(8);
        endcase
        return f;
    endfunction

endpackage

// File: rtl/pfd_cmp_fsm.sv
module pfd_cmp_fsm
    import pfd_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fb_pulse,
    input  logic ref_pulse,
    input  logic dir_sel,
    input  logic det_en,
    output logic pump_up,
    output logic pump_dn,
    output logic err_phase,
    output logic period_end
);

    pd_state_e state, nxt;
    logic fb_q, ref_q;
    logic fb_rise, ref_rise;
    logic up_edge, dn_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_q  <= 1'b0;
            ref_q <= 1'b0;
        end else begin
            fb_q  <= fb_pulse;
            ref_q <= ref_pulse;
        end
    end

    assign fb_rise  = fb_pulse & ~fb_q;
    assign ref_rise = ref_pulse & ~ref_q;
    assign up_edge  = dir_sel ? ref_rise : fb_rise;
    assign dn_edge  = dir_sel ? fb_rise  : ref_rise;

    always_comb begin
        nxt = state;
        if (!det_en) begin
            nxt = PD_IDLE;
        end else begin
            unique case (state)
                PD_IDLE, PD_OVERLAP: begin
                    if (up_edge && dn_edge) nxt = PD_OVERLAP;
                    else if (up_edge)       nxt = PD_UP_ON;
                    else if (dn_edge)       nxt = PD_DN_ON;
                    else                    nxt = PD_IDLE;
                end
                PD_UP_ON: nxt = dn_edge ? PD_OVERLAP : PD_UP_ON;
                PD_DN_ON: nxt = up_edge ? PD_OVERLAP : PD_DN_ON;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= PD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        pump_up    = 1'b0;
        pump_dn    = 1'b0;
        err_phase  = 1'b0;
        period_end = 1'b0;
        unique case (state)
            PD_IDLE: ;
            PD_UP_ON: begin
                pump_up   = det_en;
                err_phase = 1'b1;
            end
            PD_DN_ON: begin
                pump_dn   = det_en;
                err_phase = 1'b1;
            end
            PD_OVERLAP: begin
                pump_up    = det_en;
                pump_dn    = det_en;
                period_end = 1'b1;
            end
        endcase
    end

    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && !pump_dn && det_en) |=> (pump_up || !det_en)); // R1
    AST_DN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_dn && !pump_up && det_en) |=> (pump_dn || !det_en)); // R2
    AST_OVERLAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (pump_up && pump_dn) |=> !(pump_up && pump_dn)); // R3
    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |-> (!pump_up && !pump_dn)); // R4

endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
    import pfd_dir_pkg::*;
#(
    parameter int LOCK_PERIODS = 16,
    parameter int ERR_THRESH   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic err_phase,
    input  logic period_end,
    output logic locked
);

    localparam int ERR_W  = $clog2(ERR_THRESH + 2);
    localparam int GOOD_W = $clog2(LOCK_PERIODS + 1);
    localparam logic [ERR_W-1:0]  ERR_LIM   = ERR_W'(ERR_THRESH);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_PERIODS - 1);
    localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(LOCK_PERIODS);

    lk_state_e lk_state, lk_nxt;
    logic [ERR_W-1:0]  err_cnt;
    logic [GOOD_W-1:0] good_cnt;
    logic bad_now, good_end, reach;

    assign bad_now  = err_phase && (err_cnt >= ERR_LIM);
    assign good_end = period_end && (err_cnt <= ERR_LIM);
    assign reach    = good_end && (good_cnt >= GOOD_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !det_en) begin
            err_cnt  <= '0;
            good_cnt <= '0;
        end else if (err_phase) begin
            if (err_cnt <= ERR_LIM) err_cnt <= err_cnt + 1'b1;
            if (bad_now)            good_cnt <= '0;
        end else if (period_end) begin
            err_cnt <= '0;
            if (good_end && good_cnt < GOOD_MAX) good_cnt <= good_cnt + 1'b1;
        end
    end

    always_comb begin
        lk_nxt = lk_state;
        if (!det_en) begin
            lk_nxt = LK_HUNT;
        end else begin
            unique case (lk_state)
                LK_HUNT: if (reach)   lk_nxt = LK_HELD;
                LK_HELD: if (bad_now) lk_nxt = LK_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lk_state <= LK_HUNT;
        else        lk_state <= lk_nxt;
    end

    always_comb begin
        unique case (lk_state)
            LK_HUNT: locked = 1'b0;
            LK_HELD: locked = 1'b1;
        endcase
    end

    AST_LOCK_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |=> !locked); // R4
    AST_LOCK_AT_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(period_end)); // R8
    AST_LOCK_DROP_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(err_phase) || $past(!det_en))); // R9

endmodule

// File: rtl/pfd_mon_mux.sv
module pfd_mon_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic fb_pulse,
    input  logic ref_pulse,
    input  logic dir_sel,
    input  logic mon_en,
    output logic mon_a,
    output logic mon_b
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mon_a <= 1'b0;
            mon_b <= 1'b0;
        end else begin
            mon_a <= mon_en & (dir_sel ? fb_pulse  : ref_pulse);
            mon_b <= mon_en & (dir_sel ? ref_pulse : fb_pulse);
        end
    end

    AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (!mon_a && !mon_b)); // R6
    AST_MON_RF_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && dir_sel && fb_pulse) |=> mon_a); // R5

endmodule

// File: rtl/pfd_dir_ctrl.sv
module pfd_dir_ctrl
    import pfd_dir_pkg::*;
#(
    parameter int LOCK_PERIODS = 16,
    parameter int ERR_THRESH   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fb_pulse,
    input  logic              ref_pulse,
    input  logic              dir_sel,
    input  logic              det_en,
    input  logic              mon_en,
    input  logic [1:0]        gain_code,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              mon_a,
    output logic              mon_b,
    output logic [GAIN_W-1:0] gain_scale,
    output logic              locked
);

    logic err_phase, period_end;

    pfd_cmp_fsm u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .fb_pulse   (fb_pulse),
        .ref_pulse  (ref_pulse),
        .dir_sel    (dir_sel),
        .det_en     (det_en),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn),
        .err_phase  (err_phase),
        .period_end (period_end)
    );

    pfd_lock_filter #(
        .LOCK_PERIODS (LOCK_PERIODS),
        .ERR_THRESH   (ERR_THRESH)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .det_en     (det_en),
        .err_phase  (err_phase),
        .period_end (period_end),
        .locked     (locked)
    );

    pfd_mon_mux u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .fb_pulse  (fb_pulse),
        .ref_pulse (ref_pulse),
        .dir_sel   (dir_sel),
        .mon_en    (mon_en),
        .mon_a     (mon_a),
        .mon_b     (mon_b)
    );

    assign gain_scale = gain_decode(gain_code);

    AST_GAIN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_scale == 4'd2 || gain_scale == 4'd3 ||
         gain_scale == 4'd5 || gain_scale == 4'd8)); // R7

endmodule

// File: tb/pfd_dir_ctrl_tb.sv
module pfd_dir_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LOCKP = 4;
    localparam int THR   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fb_pulse = 1'b0, ref_pulse = 1'b0;
    logic dir_sel = 1'b1, det_en = 1'b1, mon_en = 1'b1;
    logic [1:0] gain_code = 2'b00;
    logic pump_up, pump_dn, mon_a, mon_b, locked;
    logic [3:0] gain_scale;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        int    up_w;
        int    dn_w;
        string req;
    } exp_t;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pfd_dir_ctrl #(.LOCK_PERIODS(LOCKP), .ERR_THRESH(THR)) dut_i (
        .clk(clk), .rst_n(rst_n), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse),
        .dir_sel(dir_sel), .det_en(det_en), .mon_en(mon_en),
        .gain_code(gain_code), .pump_up(pump_up), .pump_dn(pump_dn),
        .mon_a(mon_a), .mon_b(mon_b), .gain_scale(gain_scale), .locked(locked)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor: measures pulse widths per period, closes at the overlap cycle
    int acc_up = 0, acc_dn = 0;
    always begin
        @(negedge clk);
        #1;
        if (rst_n && (pump_up || pump_dn)) begin
            acc_up += int'(pump_up);
            acc_dn += int'(pump_dn);
            if (pump_up && pump_dn) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected period", acc_up, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(acc_up == e.up_w, {e.req, " up width"}, acc_up, e.up_w);
                    chk(acc_dn == e.dn_w, {e.req, " dn width"}, acc_dn, e.dn_w);
                end
                acc_up = 0;
                acc_dn = 0;
            end
        end
    end

    // offset > 0: reference edge leads by offset cycles; < 0: RF edge leads
    task automatic pair(input int offset, input bit expect_pulse, input string req);
        int tr, tf, k, last;
        exp_t e;
        tr = (offset < 0) ? -offset : 0;
        tf = (offset > 0) ? offset : 0;
        k  = (offset < 0) ? -offset : offset;
        last = ((tr > tf) ? tr : tf) + 8;
        if (expect_pulse) begin
            e.req = req;
            if (offset == 0) begin
                e.up_w = 1; e.dn_w = 1;
            end else if ((offset > 0) == dir_sel) begin
                e.up_w = k + 1; e.dn_w = 1;
            end else begin
                e.up_w = 1; e.dn_w = k + 1;
            end
            sb_q.push_back(e);
        end
        for (int c = 0; c <= last; c++) begin
            @(negedge clk);
            ref_pulse = (c == tr || c == tr + 1);
            fb_pulse  = (c == tf || c == tf + 1);
            if (!expect_pulse) begin
                #1;
                chk(!pump_up && !pump_dn, "R4 pump while disabled",
                    int'(pump_up) + int'(pump_dn), 0);
            end
        end
    endtask

    task automatic chk_locked(input bit exp, input string req);
        @(negedge clk);
        #1;
        chk(locked == exp, req, int'(locked), int'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        chk(!pump_up && !pump_dn && !mon_a && !mon_b && !locked, "R10 reset outputs",
            int'(pump_up) + int'(pump_dn) + int'(mon_a) + int'(mon_b) + int'(locked), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7 gain decode
        for (int g = 0; g < 4; g++) begin
            int expv;
            @(negedge clk);
            gain_code = 2'(g);
            #1;
            expv = (g == 0) ? 2 : (g == 1) ? 3 : (g == 2) ? 5 : 8;
            chk(int'(gain_scale) == expv, "R7 gain decode", int'(gain_scale), expv);
        end

        // R1 / R3 direction high
        dir_sel = 1'b1;
        pair(0, 1'b1, "R3 coincident");
        pair(1, 1'b1, "R1 ref leads by 1");
        pair(5, 1'b1, "R1 ref leads by 5");
        pair(-3, 1'b1, "R1 rf leads by 3");
        // R2 direction low
        @(negedge clk);
        dir_sel = 1'b0;
        pair(2, 1'b1, "R2 ref leads by 2");
        pair(-4, 1'b1, "R2 rf leads by 4");
        pair(0, 1'b1, "R3 coincident dir low");

        // R8 / R9 lock filter
        @(negedge clk);
        dir_sel = 1'b1;
        pair(4, 1'b1, "R9 bad period");
        chk_locked(1'b0, "R9 unlocked after bad period");
        for (int i = 0; i < LOCKP - 1; i++) begin
            pair(THR, 1'b1, "R8 quiet period");
            chk_locked(1'b0, "R8 not yet locked");
        end
        pair(-THR, 1'b1, "R8 final quiet period");
        chk_locked(1'b1, "R8 lock after quiet periods");
        pair(THR + 1, 1'b1, "R9 error above threshold");
        chk_locked(1'b0, "R9 lock drops on error");
        for (int i = 0; i < LOCKP - 1; i++) begin
            pair(1, 1'b1, "R9 recount");
            chk_locked(1'b0, "R9 count restarted");
        end
        pair(0, 1'b1, "R9 recount last");
        chk_locked(1'b1, "R8 relock");

        // R4 disable
        @(negedge clk);
        det_en = 1'b0;
        chk_locked(1'b0, "R4 lock cleared by disable");
        pair(3, 1'b0, "R4");
        pair(0, 1'b0, "R4");

        // R5 / R6 monitors (detector disabled so no periods open)
        for (int d = 0; d < 2; d++) begin
            @(negedge clk);
            dir_sel = d[0];
            mon_en = 1'b1;
            fb_pulse = 1'b1;
            ref_pulse = 1'b0;
            @(negedge clk);
            #1;
            chk(mon_a == d[0], "R5 monitor a rf", int'(mon_a), d);
            chk(mon_b == !d[0], "R5 monitor b rf", int'(mon_b), 1 - d);
            fb_pulse = 1'b0;
            ref_pulse = 1'b1;
            @(negedge clk);
            #1;
            chk(mon_a == !d[0], "R5 monitor a ref", int'(mon_a), 1 - d);
            chk(mon_b == d[0], "R5 monitor b ref", int'(mon_b), d);
        end
        @(negedge clk);
        mon_en = 1'b0;
        fb_pulse = 1'b1;
        ref_pulse = 1'b1;
        @(negedge clk);
        #1;
        chk(!mon_a && !mon_b, "R6 monitors gated", int'(mon_a) + int'(mon_b), 0);
        fb_pulse = 1'b0;
        ref_pulse = 1'b0;

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule